// File: doc/BRIEF.md
# Eye Monitor Sweep and Readout Sequencer

This block steps an eye-opening monitor through a two-dimensional grid of sampling-phase and threshold-voltage offsets. At each grid point it counts comparator error events over a programmable window. Each 16-bit result is exposed as two bytes on a simple register read/write port. The comparator itself sits outside the block; its verdict arrives on `err_i`, one sample per clock.

Readout drives the sweep. Reading the high byte of a finished point has two effects: the offsets step to the next point (phase innermost, then voltage) and the counter restarts. The low byte can be fetched in either of two ways:
- Streaming: read the data address a second time.
- Addressed: read a separate low-byte address.

A self-clearing start bit stays high until the last point has been fully read. The block also holds a 2-bit voltage-range code, which it drives to the analog side and otherwise does not use.

Top module: `eye_sweep_seq`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the phase and voltage indices are 0 and the range output is 0.
- R2: Writing address 0 sets the fast-sweep enable from bit 7 and the manual-override flag from bit 6. A write with bit 0 set starts a sweep only if bit 7 is 1 and bit 6 is 0 in that write. Otherwise the start bit (bit 0) stays 0 and the indices do not move.
- R3: Each grid point counts the clock cycles with `err_i` high over a window of (W+1)·2^UNIT_SHIFT cycles, where W is the byte held at address 3.
- R4: If the current point's window has finished, a read of address 1 returns result bits 15:8. It also advances the grid to the next point, with phase incrementing first, and restarts the count.
- R5: After a high-byte read, the next read of address 1 returns result bits 7:0 of the same point.
- R6: After a high-byte read, address 2 returns result bits 7:0. No new result is latched into the byte registers until that low byte has been read.
- R7: A high-byte read before the current window has finished returns the last completed result. It leaves the offsets and the running count unchanged.
- R8: The grid holds 2^IDX_W phase by 2^IDX_W voltage points. The start bit reads 1 throughout the sweep and returns to 0 once the low byte of the last point has been read.
- R9: The error count saturates at 0xFFFF.
- R10: A write to address 4 sets the 2-bit range code from bits 1:0. The code drives `range_o` and reads back at address 4.
- R11: The window byte at address 3 reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (read side effects apply at the clock edge) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| err_i | input | 1 | Comparator error event, one sample per cycle |
| phase_o | output | IDX_W | Current phase offset index |
| volt_o | output | IDX_W | Current voltage offset index |
| range_o | output | 2 | Voltage range code (0..3 selects ±100..±400 mV) |

## Verification
The assertions assume that a write and a read strobe are never asserted in the same cycle. They also assume that the grid indices and the range code can change only in response to register traffic, so any movement can be traced to a register access on the previous cycle. The bench drives one access at a time, each held for exactly one clock. It changes `err_i` only while no window is running, or at the same edge as the read that restarts the counter. Each window therefore sees a constant input, and its count is known exactly.

// File: rtl/eye_pkg.sv
package eye_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LSB   = 3'd2;
  localparam logic [ADDR_W-1:0] A_WIN   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RANGE = 3'd4;
  localparam int B_FAST  = 7;
  localparam int B_OVR   = 6;
  localparam int B_START = 0;
  localparam int CNT_W   = 16;
endpackage

// File: rtl/eye_accum.sv
module eye_accum #(
  parameter int CNT_W      = 16,
  parameter int WIN_W      = 8,
  parameter int UNIT_SHIFT = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic             err_i,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int TW = WIN_W + UNIT_SHIFT + 1;

  logic [TW-1:0]    tcnt_q, limit;
  logic [CNT_W-1:0] ecnt_q, ecnt_d;

  assign limit  = (TW'(win_i) + TW'(1)) << UNIT_SHIFT;
  assign ecnt_d = (&ecnt_q) ? ecnt_q : ecnt_q + CNT_W'(err_i);
  assign done_o  = run_i && (tcnt_q == limit - TW'(1));
  assign count_o = ecnt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q <= '0;
      ecnt_q <= '0;
    end else if (restart_i) begin
      tcnt_q <= '0;
      ecnt_q <= '0;
    end else if (run_i) begin
      tcnt_q <= tcnt_q + TW'(1);
      ecnt_q <= ecnt_d;
    end
  end
endmodule

// File: rtl/eye_grid.sv
module eye_grid #(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] phase_o,
  output logic [IDX_W-1:0] volt_o,
  output logic             last_o
);
  localparam int PW = 2 * IDX_W;

  logic [PW-1:0] idx_q;

  // phase in low bits so it wraps first
  assign phase_o = idx_q[IDX_W-1:0];
  assign volt_o  = idx_q[PW-1:IDX_W];
  assign last_o  = &idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (step_i) idx_q <= idx_q + PW'(1);
  end
endmodule

// File: rtl/eye_sweep_seq.sv
module eye_sweep_seq
  import eye_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int UNIT_SHIFT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              err_i,
  output logic [IDX_W-1:0]  phase_o,
  output logic [IDX_W-1:0]  volt_o,
  output logic [1:0]        range_o
);
  logic             fast_q, ovr_q, active_q, done_q, fin_q, pend_q;
  logic [7:0]       win_q, lsb_q;
  logic [1:0]       range_q;
  logic [CNT_W-1:0] res_q, acc_cnt;
  logic             acc_done, last_pt;
  logic             start_ok, msb_rd, lsb_rd, adv, run;

  assign start_ok = wr_i && addr_i == A_CTRL && wdata_i[B_FAST] && !wdata_i[B_OVR]
                    && wdata_i[B_START] && !active_q;
  assign msb_rd   = rd_i && addr_i == A_DATA && active_q && !pend_q;
  assign lsb_rd   = rd_i && pend_q && (addr_i == A_DATA || addr_i == A_LSB);
  assign adv      = msb_rd && done_q;
  assign run      = active_q && !done_q && !fin_q;

  eye_accum #(.CNT_W(CNT_W), .WIN_W(8), .UNIT_SHIFT(UNIT_SHIFT)) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (start_ok || adv),
    .win_i     (win_q),
    .err_i     (err_i),
    .done_o    (acc_done),
    .count_o   (acc_cnt)
  );

  eye_grid #(.IDX_W(IDX_W)) u_grid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_ok),
    .step_i  (adv && !last_pt),
    .phase_o (phase_o),
    .volt_o  (volt_o),
    .last_o  (last_pt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q  <= 1'b0;
      ovr_q   <= 1'b0;
      win_q   <= '0;
      range_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_CTRL: begin
          fast_q <= wdata_i[B_FAST];
          ovr_q  <= wdata_i[B_OVR];
        end
        A_WIN:   win_q   <= wdata_i;
        A_RANGE: range_q <= wdata_i[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      fin_q    <= 1'b0;
      pend_q   <= 1'b0;
      res_q    <= '0;
      lsb_q    <= '0;
    end else if (start_ok) begin
      active_q <= 1'b1;
      done_q   <= 1'b0;
      fin_q    <= 1'b0;
      pend_q   <= 1'b0;
      res_q    <= '0;
    end else begin
      if (acc_done) begin
        res_q  <= acc_cnt;
        done_q <= 1'b1;
      end
      if (adv) begin
        done_q <= 1'b0;
        if (last_pt) fin_q <= 1'b1;
      end
      // high byte read: freeze low byte of the same result
      if (msb_rd) begin
        pend_q <= 1'b1;
        lsb_q  <= res_q[7:0];
      end
      if (lsb_rd) begin
        pend_q <= 1'b0;
        if (fin_q) active_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = {fast_q, ovr_q, 5'b0, active_q};
      A_DATA:  rdata_o = pend_q ? lsb_q : res_q[15:8];
      A_LSB:   rdata_o = lsb_q;
      A_WIN:   rdata_o = win_q;
      A_RANGE: rdata_o = {6'b0, range_q};
      default: rdata_o = 8'h00;
    endcase
  end

  assign range_o = range_q;
endmodule

// File: rtl/eye_sweep_chk.sv
module eye_sweep_chk
  import eye_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic [IDX_W-1:0]  phase_o,
  input logic [IDX_W-1:0]  volt_o,
  input logic [1:0]        range_o,
  input logic              active_i,
  input logic              done_i,
  input logic              pend_i
);
  // R2
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_i) |-> $past(wr_i && addr_i == A_CTRL && wdata_i[B_FAST]
                              && !wdata_i[B_OVR] && wdata_i[B_START]));

  // R4
  grid_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != $past(phase_o) || volt_o != $past(volt_o)) |->
      ($past(rd_i && addr_i == A_DATA && done_i && !pend_i) || $past(wr_i && addr_i == A_CTRL)));

  // R7
  early_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_DATA && !pend_i && !done_i && !wr_i) |=>
      ($stable(phase_o) && $stable(volt_o)));

  // R8
  self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_i) |-> $past(rd_i && pend_i));

  // R10
  range_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(range_o) |-> $past(wr_i && addr_i == A_RANGE));
endmodule

bind eye_sweep_seq eye_sweep_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .phase_o  (phase_o),
  .volt_o   (volt_o),
  .range_o  (range_o),
  .active_i (active_q),
  .done_i   (done_q),
  .pend_i   (pend_q)
);

// File: tb/sim_eye_sweep_seq.sv
module sim_eye_sweep_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] wr = '0, rd = '0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       err = 1'b0;
  logic [7:0] rdata0, rdata1;
  logic [1:0] ph0, vo0;
  logic [0:0] ph1, vo1;
  logic [1:0] rng0, rng1;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  eye_sweep_seq #(.IDX_W(2), .UNIT_SHIFT(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr[0]), .rd_i(rd[0]), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata0), .err_i(err),
    .phase_o(ph0), .volt_o(vo0), .range_o(rng0));

  eye_sweep_seq #(.IDX_W(1), .UNIT_SHIFT(8)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr[1]), .rd_i(rd[1]), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata1), .err_i(err),
    .phase_o(ph1), .volt_o(vo1), .range_o(rng1));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(int sel, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr[sel] = 1'b1;
    @(negedge clk);
    wr = '0;
  endtask

  task automatic do_rd(int sel, logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd[sel] = 1'b1;
    #4 d = sel ? rdata1 : rdata0;
    @(negedge clk);
    rd = '0;
  endtask

  function automatic logic pat(int k);
    return (k % 3) != 1;
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    do_rd(0, 3'd0, d);
    chk("R1 ctrl", d, 8'h00);
    chk("R1 phase", ph0, 0);
    chk("R1 volt", vo0, 0);
    chk("R1 range", rng0, 0);
  endtask

  task automatic t_start_gate();
    logic [7:0] d;
    do_wr(0, 3'd0, 8'h01);
    do_rd(0, 3'd0, d);
    chk("R2 start without fast", d, 8'h00);
    do_wr(0, 3'd0, 8'hC1);
    repeat (5) @(negedge clk);
    do_rd(0, 3'd0, d);
    chk("R2 start with override", d, 8'hC0);
    chk("R2 phase idle", ph0, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    do_wr(0, 3'd3, 8'h5A);
    do_rd(0, 3'd3, d);
    chk("R11 window readback", d, 8'h5A);
    do_wr(0, 3'd4, 8'h02);
    chk("R10 range out", rng0, 2);
    do_rd(0, 3'd4, d);
    chk("R10 range readback", d, 8'h02);
  endtask

  task automatic t_sweep();
    logic [7:0] d;
    logic [15:0] exp;
    do_wr(0, 3'd3, 8'd100);          // window 404 cycles
    err = pat(0);
    do_wr(0, 3'd0, 8'h81);
    do_rd(0, 3'd0, d);
    chk("R8 start reads 1", d, 8'h81);
    for (int k = 0; k < 16; k++) begin
      repeat (420) @(negedge clk);
      exp = pat(k) ? 16'd404 : 16'd0;
      chk("R8 phase order", ph0, k % 4);
      chk("R8 volt order", vo0, k / 4);
      err = pat(k + 1);
      do_rd(0, 3'd1, d);
      chk("R4 msb", d, exp[15:8]);
      chk("R3 window count msb", d, exp[15:8]);
      if (k == 15) begin
        do_rd(0, 3'd0, d);
        chk("R8 busy before last lsb", d, 8'h81);
      end
      if (k % 2 == 0) begin
        do_rd(0, 3'd1, d);
        chk("R5 streaming lsb", d, exp[7:0]);
      end else begin
        if (k == 1) repeat (450) @(negedge clk);
        do_rd(0, 3'd2, d);
        chk("R6 addressed lsb", d, exp[7:0]);
      end
    end
    do_rd(0, 3'd0, d);
    chk("R8 start self-clears", d, 8'h80);
  endtask

  task automatic t_early();
    logic [7:0] d;
    do_wr(0, 3'd3, 8'd3);            // window 16 cycles
    err = 1'b1;
    do_wr(0, 3'd0, 8'h81);
    repeat (30) @(negedge clk);
    err = 1'b0;
    do_rd(0, 3'd1, d);
    chk("R3 short window msb", d, 8'h00);
    do_rd(0, 3'd1, d);
    chk("R3 short window lsb", d, 8'h10);
    chk("R4 advanced", ph0, 1);
    do_rd(0, 3'd1, d);
    chk("R7 early msb stale", d, 8'h00);
    do_rd(0, 3'd1, d);
    chk("R7 early lsb stale", d, 8'h10);
    chk("R7 phase held", ph0, 1);
    repeat (30) @(negedge clk);
    do_rd(0, 3'd1, d);
    chk("R7 later msb", d, 8'h00);
    do_rd(0, 3'd1, d);
    chk("R7 later lsb fresh", d, 8'h00);
    chk("R7 advanced after window", ph0, 2);
  endtask

  task automatic t_sat();
    logic [7:0] d;
    do_wr(1, 3'd3, 8'hFF);           // window 65536 cycles
    err = 1'b1;
    do_wr(1, 3'd0, 8'h81);
    repeat (65600) @(negedge clk);
    do_rd(1, 3'd1, d);
    chk("R9 saturate msb", d, 8'hFF);
    do_rd(1, 3'd1, d);
    chk("R9 saturate lsb", d, 8'hFF);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start_gate();
    t_regs();
    t_sweep();
    t_early();
    t_sat();
    finish_run();
  end
endmodule